// File: doc/BRIEF.md
# Decrementer Timer with Conditional Auto-Reload

This block is a 32-bit down-counter that advances on a time-base enable pulse, so it runs at the same rate as the time base. When it reaches zero it raises a sticky expiry flag in a status word. A separate enable bit in a control word masks that flag to form one level-sensitive interrupt request. Software sees the block through a simple register bus: a write strobe, a two-bit address and a 32-bit data word, plus a combinational read-back of the selected register.

After expiry the counter can restart on its own from an auto-reload register. This happens only when the auto-reload enable is set and the reload value is not zero. A zero reload therefore leaves the counter parked at zero and can never re-trigger it. Software acknowledges an expiry by writing a one to the flag's bit of the status word. The control and status words are shared with other timers, but here only the decrementer's own bits are stored.

Register map (address : register): 0 = counter, 1 = auto-reload value, 2 = control word, 3 = status word.

Top module: `dec_timer`

## Requirements
- R1: The counter decrements by one on each cycle with `tb_tick_i` high and keeps its value on cycles without a tick.
- R2: A tick that moves the counter from 1 to 0 is an expiry and sets status bit 27. A counter already at 0 stays at 0 on further ticks and causes no new expiry.
- R3: `irq_o` is high exactly when status bit 27 and control bit 26 (interrupt enable) are both set.
- R4: At expiry, when control bit 22 (auto-reload enable) is set and the auto-reload register is non-zero, the counter is loaded with the auto-reload value instead of zero.
- R5: At expiry with an auto-reload value of zero, the counter stays at zero even when auto-reload is enabled.
- R6: A write to the status word (address 3) clears each stored bit written as one and leaves the bits written as zero unchanged.
- R7: When an expiry and a status write with bit 27 set fall in the same cycle, status bit 27 ends up set.
- R8: A write to the counter (address 0) loads the written value and overrides any decrement or expiry in that cycle.
- R9: After reset, the counter, the auto-reload value, the control word and the status word all read zero, and `irq_o` is low.
- R10: The control word stores only bits 26 and 22. All other control and status bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tb_tick_i | input | 1 | Time-base enable pulse, one decrement per high cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 counter, 1 reload, 2 control, 3 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the register selected by `reg_addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong counter value shows on the counter read-back in the cycle after the faulty edge. It also shows as an expiry flag that rises one or more ticks too early or too late. A lost or stuck status bit shows on the status read-back and, with the enable set, on `irq_o` in the cycle after the expiry. A wrong reload decision (reloading from zero, or ignoring the enable) shows on the very next counter read. The reference model is compared against the read-back of the selected register and against the interrupt on every clock, so any divergence is reported within one cycle of being visible.

// File: rtl/dec_timer_pkg.sv
package dec_timer_pkg;

    // register select codes on the bus
    localparam logic [1:0] SEL_COUNT  = 2'd0;
    localparam logic [1:0] SEL_RELOAD = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_STAT   = 2'd3;

    // bit positions in the shared control and status words
    localparam int unsigned IE_POS  = 26;
    localparam int unsigned ARE_POS = 22;
    localparam int unsigned EXP_POS = 27;

    // decoded write strobes, one per register
    typedef struct packed {
        logic cnt;
        logic rld;
        logic ctrl;
        logic stat;
    } wr_sel_t;

endpackage

// File: rtl/dec_count.sv
module dec_count #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         cnt_we_i,
    input  logic         rld_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         are_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rld_o,
    output logic         expire_o
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = 1'b0;
        if (cnt_we_i) begin
            st_d.cnt = wdata_i;
        end else if (tick_i && (st_q.cnt != '0)) begin
            if (st_q.cnt == ONE) begin
                expire_d = 1'b1;
                if (are_i && (st_q.rld != '0)) begin
                    st_d.cnt = st_q.rld;
                end else begin
                    st_d.cnt = '0;
                end
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
        if (rld_we_i) begin
            st_d.rld = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign rld_o    = st_q.rld;
    assign expire_o = expire_d;

endmodule

// File: rtl/dec_ctrl_stat.sv
module dec_ctrl_stat #(
    parameter int unsigned W       = 32,
    parameter int unsigned IE_BIT  = 26,
    parameter int unsigned ARE_BIT = 22,
    parameter int unsigned ST_BIT  = 27
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ctrl_we_i,
    input  logic         stat_we_i,
    input  logic         ie_wbit_i,
    input  logic         are_wbit_i,
    input  logic         clr_wbit_i,
    input  logic         expire_i,
    output logic         ie_o,
    output logic         are_o,
    output logic         stat_o,
    output logic         irq_o,
    output logic [W-1:0] ctrl_word_o,
    output logic [W-1:0] stat_word_o
);

    typedef struct packed {
        logic ie;
        logic are;
        logic flag;
    } cs_state_t;

    cs_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (ctrl_we_i) begin
            cs_d.ie  = ie_wbit_i;
            cs_d.are = are_wbit_i;
        end
        if (expire_i) begin
            cs_d.flag = 1'b1;
        end else if (stat_we_i && clr_wbit_i) begin
            cs_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    always_comb begin
        ctrl_word_o          = '0;
        ctrl_word_o[IE_BIT]  = cs_q.ie;
        ctrl_word_o[ARE_BIT] = cs_q.are;
        stat_word_o          = '0;
        stat_word_o[ST_BIT]  = cs_q.flag;
    end

    assign ie_o   = cs_q.ie;
    assign are_o  = cs_q.are;
    assign stat_o = cs_q.flag;
    assign irq_o  = cs_q.flag & cs_q.ie;

endmodule

// File: rtl/dec_timer.sv
module dec_timer
    import dec_timer_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tb_tick_i,
    input  logic         reg_we_i,
    input  logic [1:0]   reg_addr_i,
    input  logic [W-1:0] reg_wdata_i,
    output logic [W-1:0] reg_rdata_o,
    output logic         irq_o
);

    wr_sel_t      wsel;
    logic [W-1:0] cnt_val;
    logic [W-1:0] rld_val;
    logic [W-1:0] ctrl_word;
    logic [W-1:0] stat_word;
    logic         expire_w;
    logic         ie_w;
    logic         are_w;
    logic         stat_w;

    always_comb begin
        wsel      = '0;
        wsel.cnt  = reg_we_i && (reg_addr_i == SEL_COUNT);
        wsel.rld  = reg_we_i && (reg_addr_i == SEL_RELOAD);
        wsel.ctrl = reg_we_i && (reg_addr_i == SEL_CTRL);
        wsel.stat = reg_we_i && (reg_addr_i == SEL_STAT);
    end

    dec_count #(.W(W)) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tb_tick_i),
        .cnt_we_i (wsel.cnt),
        .rld_we_i (wsel.rld),
        .wdata_i  (reg_wdata_i),
        .are_i    (are_w),
        .cnt_o    (cnt_val),
        .rld_o    (rld_val),
        .expire_o (expire_w)
    );

    dec_ctrl_stat #(
        .W       (W),
        .IE_BIT  (IE_POS),
        .ARE_BIT (ARE_POS),
        .ST_BIT  (EXP_POS)
    ) u_cs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctrl_we_i   (wsel.ctrl),
        .stat_we_i   (wsel.stat),
        .ie_wbit_i   (reg_wdata_i[IE_POS]),
        .are_wbit_i  (reg_wdata_i[ARE_POS]),
        .clr_wbit_i  (reg_wdata_i[EXP_POS]),
        .expire_i    (expire_w),
        .ie_o        (ie_w),
        .are_o       (are_w),
        .stat_o      (stat_w),
        .irq_o       (irq_o),
        .ctrl_word_o (ctrl_word),
        .stat_word_o (stat_word)
    );

    always_comb begin
        case (reg_addr_i)
            SEL_COUNT:  reg_rdata_o = cnt_val;
            SEL_RELOAD: reg_rdata_o = rld_val;
            SEL_CTRL:   reg_rdata_o = ctrl_word;
            default:    reg_rdata_o = stat_word;
        endcase
    end

endmodule

// File: rtl/dec_timer_chk.sv
module dec_timer_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         tb_tick_i,
    input logic         reg_we_i,
    input logic [1:0]   reg_addr_i,
    input logic [W-1:0] reg_wdata_i,
    input logic         irq_o,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] rld_q,
    input logic         expire,
    input logic         are,
    input logic         stat
);

    logic cnt_wr;
    logic ctrl_wr;
    assign cnt_wr  = reg_we_i && (reg_addr_i == 2'd0);
    assign ctrl_wr = reg_we_i && (reg_addr_i == 2'd2);

    // R1: no tick and no write keeps the counter
    p_idle_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tb_tick_i && !cnt_wr) |=> $stable(cnt_q));

    // R2: expiry raises the status flag
    p_expiry_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire |=> stat);

    // R2: a parked counter stays parked
    p_hold_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnt_q == '0) && !cnt_wr) |=> (cnt_q == '0));

    // R3: a rising interrupt has a cause one cycle earlier
    p_irq_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(expire || ctrl_wr));

    // R4: reload at expiry
    p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire && are && (rld_q != '0)) |=> (cnt_q == $past(rld_q)));

    // R5: zero reload parks the counter
    p_zero_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire && (rld_q == '0)) |=> (cnt_q == '0));

    // R8: counter write wins
    p_cnt_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr |=> (cnt_q == $past(reg_wdata_i)));

endmodule

bind dec_timer dec_timer_chk #(.W(W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tb_tick_i   (tb_tick_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_o       (irq_o),
    .cnt_q       (cnt_val),
    .rld_q       (rld_val),
    .expire      (expire_w),
    .are         (are_w),
    .stat        (stat_w)
);

// File: tb/tb_dec_timer.sv
module tb_dec_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    longint unsigned m_cnt = 0;
    longint unsigned m_rld = 0;
    bit m_ie = 0, m_are = 0, m_st = 0;

    always #5 clk = ~clk;

    dec_timer dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tb_tick_i   (tick),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(logic [1:0] a);
        case (a)
            2'd0: return m_cnt[31:0];
            2'd1: return m_rld[31:0];
            2'd2: return (32'(m_ie) << 26) | (32'(m_are) << 22);
            default: return 32'(m_st) << 27;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] a);
        case (a)
            2'd0: return "R1 counter";
            2'd1: return "R4 reload";
            2'd2: return "R10 control";
            default: return "R2 status";
        endcase
    endfunction

    task automatic model_step();
        bit wc, exp_now;
        wc = we && (addr == 2'd0);
        exp_now = tick && !wc && (m_cnt == 1);
        if (wc) m_cnt = wdata;
        else if (tick && m_cnt != 0) begin
            if (m_cnt == 1) m_cnt = (m_are && m_rld != 0) ? m_rld : 0;
            else m_cnt = m_cnt - 1;
        end
        if (we && addr == 2'd1) m_rld = wdata;
        if (we && addr == 2'd2) begin
            m_ie  = wdata[26];
            m_are = wdata[22];
        end
        if (exp_now) m_st = 1;
        else if (we && addr == 2'd3 && wdata[27]) m_st = 0;
    endtask

    // one clock: inputs applied now, model and compare after the edge
    task automatic step(bit t, bit w, logic [1:0] a, logic [31:0] d);
        tick = t; we = w; addr = a; wdata = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag_of(a), rdata, model_rd(a));
        chk("R3 irq", {31'd0, irq}, {31'd0, m_ie & m_st});
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        step(0, 0, a, 0);
        v = rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R9 reset value", v, 32'h0);
        end
        chk("R9 reset irq", {31'd0, irq}, 32'd0);

        // R8 load, R1 count with gaps
        step(0, 1, 2'd0, 32'd5);
        rd(2'd0, v); chk("R8 counter load", v, 32'd5);
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 2'd0, 0);
            step(0, 0, 2'd0, 0);
        end
        rd(2'd0, v); chk("R1 after four ticks", v, 32'd1);

        // R2 expiry, R3 masked
        step(1, 0, 2'd3, 0);
        chk("R2 flag set", rdata, 32'h0800_0000);
        chk("R3 masked irq", {31'd0, irq}, 32'd0);

        // R10 control write of all ones
        step(0, 1, 2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R10 control bits", v, 32'h0440_0000);
        chk("R3 irq enabled", {31'd0, irq}, 32'd1);

        // R2 parked counter
        for (int i = 0; i < 5; i++) step(1, 0, 2'd0, 0);
        chk("R2 stays zero", rdata, 32'd0);

        // R6 write-one-to-clear
        step(0, 1, 2'd3, 32'hF7FF_FFFF);
        rd(2'd3, v); chk("R6 zero bit no effect", v, 32'h0800_0000);
        step(0, 1, 2'd3, 32'h0800_0000);
        rd(2'd3, v); chk("R6 cleared", v, 32'h0);
        chk("R3 irq after clear", {31'd0, irq}, 32'd0);

        // R4 auto-reload
        step(0, 1, 2'd1, 32'd3);
        step(0, 1, 2'd2, 32'h0440_0000);
        step(0, 1, 2'd0, 32'd2);
        step(1, 0, 2'd0, 0);
        step(1, 0, 2'd0, 0);
        chk("R4 reloaded", rdata, 32'd3);
        chk("R4 irq on expiry", {31'd0, irq}, 32'd1);
        step(1, 0, 2'd0, 0);
        chk("R4 counts after reload", rdata, 32'd2);

        // R5 zero reload
        step(0, 1, 2'd3, 32'h0800_0000);
        step(0, 1, 2'd1, 32'd0);
        step(0, 1, 2'd0, 32'd1);
        step(1, 0, 2'd0, 0);
        chk("R5 no reload from zero", rdata, 32'd0);
        step(1, 0, 2'd3, 0);
        chk("R5 flag from expiry", rdata, 32'h0800_0000);

        // R7 set wins over clear
        step(0, 1, 2'd3, 32'h0800_0000);
        step(0, 1, 2'd0, 32'd1);
        step(1, 1, 2'd3, 32'h0800_0000);
        chk("R7 set wins", rdata, 32'h0800_0000);

        // R8 write beats decrement
        step(0, 1, 2'd0, 32'd10);
        step(1, 1, 2'd0, 32'd7);
        chk("R8 write priority", rdata, 32'd7);
        step(0, 1, 2'd0, 32'd1);
        step(0, 1, 2'd3, 32'h0800_0000);
        step(1, 1, 2'd0, 32'd9);
        rd(2'd3, v); chk("R8 no expiry on write", v, 32'h0);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic [31:0] d;
            r = $urandom;
            d = $urandom;
            case (r[3:0])
                4'd0: d = d % 6;
                4'd1: d = d % 4;
                4'd3: d = (r[8]) ? 32'h0800_0000 : d;
                default: ;
            endcase
            if (r[7:5] == 3'd0)
                step(r[4], 1, 2'(r[1:0]), d);
            else
                step(r[4], 0, 2'(r[10:9]), 0);
        end

        finish_run();
    end

endmodule